// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This block is a watchdog timer that sits on a simple word-addressed register bus. A free-running up-counter advances once per clock while software has it enabled. When the counter steps onto a software-loaded match value, the block raises a sticky interrupt flag. Depending on how it is programmed, it can also stop the counter and clear it to zero, change a match output pin, and fire an internal system-reset pulse and an external reset pulse. Each reset pulse lasts a programmed width plus a fixed extra length.

Software clears the counter through a multi-cycle clear sequence. It can make the counter freeze while a debugger halts the core. A reset-cause flag records that the watchdog issued an internal reset. The flag survives the ordinary system reset and only a power-on reset clears it.

The register word index on `addr_i` is: 0 interrupt, 1 control, 2 counter, 3 match control, 4 match value, 5 pin control, 6 pulse width, 7 reset cause.

Top module: `mwdt_top`

## Requirements
- R1: After power-on reset every register reads zero, and `irq_o`, `match_o`, `sys_rst_o` and `ext_rst_o` are low. Reads with `sel_i` low return zero.
- R2: Control bit 0 enables counting, and the counter then advances by one per clock. Writing 0 to control stops it. The counter wraps modulo 2^CNT_W.
- R3: While control bit 2 is set, the counter holds its value in every cycle that `dbg_halt_i` is high. With bit 2 clear, `dbg_halt_i` has no effect.
- R4: Writing control with bit 1 set starts a clear. Control bit 1 reads 1 for CLR_LAT cycles, and counting pauses during that time. The counter register then reads zero.
- R5: A match occurs on the clock where the counter steps to a value equal to the match value register (index 4). A match of zero is therefore reached at wrap. A match sets interrupt bit 0 and `irq_o`, and they stay set until software writes 1 to interrupt bit 0. A match in the same cycle as that write wins.
- R6: With match control bit 2 set, a match clears the counter to zero and clears control bit 0.
- R7: Pin control bits [5:4] select the pin action on a match: 0 none, 1 drive low, 2 drive high, 3 toggle. Bit 0 reads the pin and can be written directly. A match takes priority over that write.
- R8: With match control bit 3 set, a match starts a `sys_rst_o` pulse lasting the pulse width register value (16 bits) plus PULSE_EXTRA cycles. A trigger while a pulse is running is ignored.
- R9: With match control bit 4 set, a match starts an `ext_rst_o` pulse of the same length, independently of `sys_rst_o`.
- R10: Writing match control with bit 5 (internal) or bit 6 (external) set starts the corresponding pulse at once. Both bits read back as 0.
- R11: Reset-cause bit 0 is set when an internal pulse starts. It keeps its value through `rst_ni` and is cleared only by `por_ni`. Writes to it are ignored.
- R12: Writes to the counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and bus clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_ni | input | 1 | System reset, active low, asynchronous; keeps the reset cause |
| dbg_halt_i | input | 1 | Debugger halt indication |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Sticky match interrupt |
| match_o | output | 1 | Match output pin |
| sys_rst_o | output | 1 | Internal system-reset pulse |
| ext_rst_o | output | 1 | External reset pulse |

## Verification
The bench builds the block with CNT_W=8, CLR_LAT=4, PULSE_EXTRA=6 and a 16-bit pulse width. The narrow counter brings wrap-around, and a match of zero reached at wrap, within a few hundred cycles. The longer clear latency makes the paused-counting window clearly observable. Programming widths of a few cycles lets whole reset pulses, retrigger attempts and overlapping internal and external pulses complete within one test phase.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;

  typedef enum logic [2:0] {
    REG_IRQ   = 3'd0,
    REG_CTL   = 3'd1,
    REG_CNT   = 3'd2,
    REG_MCTL  = 3'd3,
    REG_MVAL  = 3'd4,
    REG_PIN   = 3'd5,
    REG_PW    = 3'd6,
    REG_CAUSE = 3'd7
  } mwdt_reg_e;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } mwdt_pin_e;

  localparam int DW = 32;

  // bit positions decoded by software
  localparam int CTL_EN   = 0;
  localparam int CTL_CLR  = 1;
  localparam int CTL_DBG  = 2;
  localparam int MC_STOP  = 2;
  localparam int MC_IRST  = 3;
  localparam int MC_ERST  = 4;
  localparam int MC_IFRC  = 5;
  localparam int MC_EFRC  = 6;

endpackage

// File: rtl/mwdt_count.sv
module mwdt_count #(
  parameter int CNT_W   = 32,
  parameter int CLR_LAT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             hit_o
);

  localparam int LW = $clog2(CLR_LAT + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [LW-1:0]    clr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             step;

  assign busy_o  = (clr_q != '0);
  assign step    = run_i && !busy_o;
  assign cnt_inc = cnt_q + ONE;
  assign hit_o   = step && (cnt_inc == match_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (clr_i)       clr_q <= LW'(CLR_LAT);
      else if (busy_o) clr_q <= clr_q - LW'(1);

      // clear completes on the last latency cycle
      if (busy_o && clr_q == LW'(1)) cnt_q <= '0;
      else if (step)                 cnt_q <= (hit_o && stop_i) ? '0 : cnt_inc;
    end
  end

endmodule

// File: rtl/mwdt_pulse.sv
module mwdt_pulse #(
  parameter int PW_W  = 16,
  parameter int EXTRA = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic [PW_W-1:0] width_i,
  output logic            start_o,
  output logic            act_o
);

  localparam int CW = PW_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load;

  assign load    = CW'(width_i) + CW'(EXTRA);
  assign act_o   = (cnt_q != '0);
  assign start_o = trig_i && !act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_o) cnt_q <= load;
    else if (act_o)   cnt_q <= cnt_q - CW'(1);
  end

endmodule

// File: rtl/mwdt_top.sv
module mwdt_top
  import mwdt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PW_W        = 16,
  parameter int PULSE_EXTRA = 6,
  parameter int CLR_LAT     = 3
) (
  input  logic        clk_i,
  input  logic        por_ni,
  input  logic        rst_ni,
  input  logic        dbg_halt_i,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        match_o,
  output logic        sys_rst_o,
  output logic        ext_rst_o
);

  localparam int NPULSE = 2;

  logic             rst_n;
  logic             wr_en;
  mwdt_reg_e        reg_sel;

  logic             en_q, dbg_q;
  logic             stop_q, irst_q, erst_q;
  mwdt_pin_e        mode_q;
  logic             pin_q;
  logic [PW_W-1:0]  pw_q;
  logic [CNT_W-1:0] mval_q;
  logic             irq_q;
  logic             cause_q;

  logic             run, clr_req, hit, busy;
  logic [CNT_W-1:0] cnt;
  logic             irq_clr;
  logic [NPULSE-1:0] trig, start, act;

  assign rst_n   = por_ni & rst_ni;
  assign wr_en   = sel_i & wr_i;
  assign reg_sel = mwdt_reg_e'(addr_i);

  assign run     = en_q && !(dbg_q && dbg_halt_i);
  assign clr_req = wr_en && reg_sel == REG_CTL && wdata_i[CTL_CLR];
  assign irq_clr = wr_en && reg_sel == REG_IRQ && wdata_i[0];

  mwdt_count #(
    .CNT_W  (CNT_W),
    .CLR_LAT(CLR_LAT)
  ) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run),
    .clr_i  (clr_req),
    .stop_i (stop_q),
    .match_i(mval_q),
    .cnt_o  (cnt),
    .busy_o (busy),
    .hit_o  (hit)
  );

  assign trig[0] = (hit && irst_q) || (wr_en && reg_sel == REG_MCTL && wdata_i[MC_IFRC]);
  assign trig[1] = (hit && erst_q) || (wr_en && reg_sel == REG_MCTL && wdata_i[MC_EFRC]);

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    mwdt_pulse #(
      .PW_W (PW_W),
      .EXTRA(PULSE_EXTRA)
    ) u_pulse (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .trig_i (trig[g]),
      .width_i(pw_q),
      .start_o(start[g]),
      .act_o  (act[g])
    );
  end

  assign sys_rst_o = act[0];
  assign ext_rst_o = act[1];
  assign irq_o     = irq_q;
  assign match_o   = pin_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dbg_q  <= 1'b0;
      stop_q <= 1'b0;
      irst_q <= 1'b0;
      erst_q <= 1'b0;
      mode_q <= PIN_KEEP;
      pin_q  <= 1'b0;
      pw_q   <= '0;
      mval_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en && reg_sel == REG_CTL) begin
        en_q  <= wdata_i[CTL_EN];
        dbg_q <= wdata_i[CTL_DBG];
      end else if (hit && stop_q) begin
        en_q  <= 1'b0;
      end

      if (wr_en && reg_sel == REG_MCTL) begin
        stop_q <= wdata_i[MC_STOP];
        irst_q <= wdata_i[MC_IRST];
        erst_q <= wdata_i[MC_ERST];
      end

      if (hit)          irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;

      if (hit) begin
        unique case (mode_q)
          PIN_LOW:    pin_q <= 1'b0;
          PIN_HIGH:   pin_q <= 1'b1;
          PIN_TOGGLE: pin_q <= ~pin_q;
          default:    pin_q <= pin_q;
        endcase
      end else if (wr_en && reg_sel == REG_PIN) begin
        pin_q <= wdata_i[0];
      end
      if (wr_en && reg_sel == REG_PIN) mode_q <= mwdt_pin_e'(wdata_i[5:4]);

      if (wr_en && reg_sel == REG_PW)   pw_q   <= wdata_i[PW_W-1:0];
      if (wr_en && reg_sel == REG_MVAL) mval_q <= wdata_i[CNT_W-1:0];
    end
  end

  // cause lives in the power-on domain only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                  cause_q <= 1'b0;
    else if (rst_ni && start[0])  cause_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (reg_sel)
        REG_IRQ:   rdata_o[0] = irq_q;
        REG_CTL:   begin
          rdata_o[CTL_EN]  = en_q;
          rdata_o[CTL_CLR] = busy;
          rdata_o[CTL_DBG] = dbg_q;
        end
        REG_CNT:   rdata_o = DW'(cnt);
        REG_MCTL:  begin
          rdata_o[MC_STOP] = stop_q;
          rdata_o[MC_IRST] = irst_q;
          rdata_o[MC_ERST] = erst_q;
        end
        REG_MVAL:  rdata_o = DW'(mval_q);
        REG_PIN:   begin
          rdata_o[0]   = pin_q;
          rdata_o[5:4] = mode_q;
        end
        REG_PW:    rdata_o = DW'(pw_q);
        REG_CAUSE: rdata_o[0] = cause_q;
        default:   rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/mwdt_chk.sv
module mwdt_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             por_ni,
  input logic             en,
  input logic             dbg,
  input logic             halt,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic             irq_clr,
  input logic             hit,
  input logic [1:0]       mode,
  input logic             pin,
  input logic             trig0,
  input logic             sys_rst,
  input logic             cause
);

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en && !busy) |=> $stable(cnt));

  // R3
  dbg_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en && dbg && halt && !busy) |=> $stable(cnt));

  // R5
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R5
  hit_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit |=> irq);

  // R7
  pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hit && mode == 2'd2) |=> pin);

  // R8
  sys_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(trig0));

  // R11
  cause_keep_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    cause |=> cause);

endmodule

bind mwdt_top mwdt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i  (clk_i),
  .rst_n  (rst_n),
  .por_ni (por_ni),
  .en     (en_q),
  .dbg    (dbg_q),
  .halt   (dbg_halt_i),
  .busy   (busy),
  .cnt    (cnt),
  .irq    (irq_q),
  .irq_clr(irq_clr),
  .hit    (hit),
  .mode   (mode_q),
  .pin    (pin_q),
  .trig0  (trig[0]),
  .sys_rst(sys_rst_o),
  .cause  (cause_q)
);

// File: tb/mwdt_top_tb_top.sv
`timescale 1ns/1ps
module mwdt_top_tb_top;

  localparam int CW  = 8;
  localparam int CL  = 4;
  localparam int EXT = 6;
  localparam int WD_LIM = 20000;

  logic        clk_i = 1'b0;
  logic        por_ni = 1'b0, rst_ni = 1'b1, dbg_halt_i = 1'b0;
  logic        sel_i = 1'b0, wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, match_o, sys_rst_o, ext_rst_o;

  always #2.5 clk_i = ~clk_i;

  mwdt_top #(.CNT_W(CW), .PW_W(16), .PULSE_EXTRA(EXT), .CLR_LAT(CL)) dut_i (
    .clk_i(clk_i), .por_ni(por_ni), .rst_ni(rst_ni), .dbg_halt_i(dbg_halt_i),
    .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .match_o(match_o),
    .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
  );

  // behavioural reference state
  int unsigned m_cnt, m_mval, m_pw, m_clr;
  int unsigned m_pc[2];
  bit m_en, m_dbg, m_stop, m_irst, m_erst, m_pin, m_irq, m_cause;
  bit [1:0] m_mode;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic int unsigned mask(int unsigned v);
    return v % (1 << CW);
  endfunction

  always @(posedge clk_i or negedge por_ni or negedge rst_ni) begin
    if (!por_ni || !rst_ni) begin
      m_cnt = 0; m_mval = 0; m_pw = 0; m_clr = 0; m_pc[0] = 0; m_pc[1] = 0;
      m_en = 0; m_dbg = 0; m_stop = 0; m_irst = 0; m_erst = 0;
      m_pin = 0; m_irq = 0; m_mode = 0;
      if (!por_ni) m_cause = 0;
    end else begin
      bit w, run, hit;
      bit tr[2];
      int unsigned a, nxt;
      logic [31:0] d;
      w = sel_i && wr_i; a = addr_i; d = wdata_i;
      run = m_en && !(m_dbg && dbg_halt_i) && m_clr == 0;
      nxt = mask(m_cnt + 1);
      hit = run && nxt == m_mval;
      tr[0] = (hit && m_irst) || (w && a == 3 && d[5]);
      tr[1] = (hit && m_erst) || (w && a == 3 && d[6]);
      if (m_clr == 1) m_cnt = 0;
      else if (run)   m_cnt = (hit && m_stop) ? 0 : nxt;
      if (w && a == 1 && d[1]) m_clr = CL;
      else if (m_clr > 0)      m_clr = m_clr - 1;
      if (w && a == 1) begin m_en = d[0]; m_dbg = d[2]; end
      else if (hit && m_stop) m_en = 0;
      if (hit) m_irq = 1;
      else if (w && a == 0 && d[0]) m_irq = 0;
      if (hit) begin
        if (m_mode == 1) m_pin = 0;
        else if (m_mode == 2) m_pin = 1;
        else if (m_mode == 3) m_pin = !m_pin;
      end else if (w && a == 5) m_pin = d[0];
      if (w && a == 5) m_mode = d[5:4];
      for (int k = 0; k < 2; k++) begin
        if (tr[k] && m_pc[k] == 0) begin
          m_pc[k] = m_pw + EXT;
          if (k == 0) m_cause = 1;
        end else if (m_pc[k] > 0) m_pc[k] = m_pc[k] - 1;
      end
      if (w && a == 6) m_pw = d[15:0];
      if (w && a == 4) m_mval = mask(d);
      if (w && a == 3) begin m_stop = d[2]; m_irst = d[3]; m_erst = d[4]; end
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    if (!sel_i) return r;
    case (addr_i)
      3'd0: r[0] = m_irq;
      3'd1: begin r[0] = m_en; r[1] = (m_clr != 0); r[2] = m_dbg; end
      3'd2: r = m_cnt;
      3'd3: begin r[2] = m_stop; r[3] = m_irst; r[4] = m_erst; end
      3'd4: r = m_mval;
      3'd5: begin r[0] = m_pin; r[5:4] = m_mode; end
      3'd6: r = m_pw;
      default: r[0] = m_cause;
    endcase
    return r;
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #1;
    cmp(cur_req, rdata_o, exp_rd());
    cmp("R5", 32'(irq_o), 32'(m_irq));
    cmp("R7", 32'(match_o), 32'(m_pin));
    cmp("R8", 32'(sys_rst_o), 32'(m_pc[0] != 0));
    cmp("R9", 32'(ext_rst_o), 32'(m_pc[1] != 0));
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIM && !done) begin
      n_bad++;
      $display("FAIL %s watchdog expired actual=%0d expected<%0d", cur_req, cyc, WD_LIM);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    sel_i = 1; wr_i = 1; addr_i = 3'(a); wdata_i = d;
    @(negedge clk_i);
    sel_i = 0; wr_i = 0; wdata_i = '0;
  endtask

  task automatic peek(int a, int n);
    sel_i = 1; wr_i = 0; addr_i = 3'(a);
    repeat (n) @(negedge clk_i);
    sel_i = 0;
  endtask

  task automatic restart();
    wr(1, 32'h2);
    peek(2, CL + 1);
    wr(1, 32'h1);
  endtask

  initial begin
    // R1: reset state of every register
    repeat (3) @(negedge clk_i);
    por_ni = 1;
    for (int a = 0; a < 8; a++) peek(a, 1);
    peek(2, 1); sel_i = 0; @(negedge clk_i);

    cur_req = "R2"; // counting, stop, wrap to match zero
    wr(1, 32'h1); peek(2, 6);
    wr(1, 32'h0); peek(2, 3);
    wr(1, 32'h1); peek(2, 300); // wraps, match of 0 hits
    wr(0, 32'h1);

    cur_req = "R3"; // debug freeze
    wr(1, 32'h5); dbg_halt_i = 1; peek(2, 4);
    dbg_halt_i = 0; peek(2, 2);
    wr(1, 32'h1); dbg_halt_i = 1; peek(2, 3); dbg_halt_i = 0;

    cur_req = "R4"; // clear sequence
    wr(1, 32'h3); peek(1, 2); peek(2, CL + 2); peek(1, 1);

    cur_req = "R5"; // sticky interrupt and clear
    wr(4, 32'h5); restart(); peek(0, 10);
    wr(0, 32'h1); peek(0, 3);
    wr(4, 32'h3); restart(); peek(2, 2);
    wr(0, 32'h1); peek(0, 3); wr(0, 32'h1);

    cur_req = "R6"; // stop on match
    wr(3, 32'h4); wr(4, 32'h4); restart(); peek(2, 8); peek(1, 2);

    cur_req = "R7"; // pin modes
    wr(5, 32'h20); wr(4, 32'h3); restart(); peek(5, 6);
    wr(5, 32'h30); restart(); peek(5, 6);
    restart(); peek(5, 6);
    wr(5, 32'h11); restart(); peek(5, 6);
    wr(5, 32'h01); peek(5, 2);

    cur_req = "R8"; // internal pulse on match
    wr(6, 32'h3); wr(3, 32'h0C); restart(); peek(7, 16);

    cur_req = "R9"; // external pulse on match
    wr(3, 32'h14); restart(); peek(6, 16);

    cur_req = "R10"; // forced pulses, retrigger ignored
    wr(6, 32'h2); wr(3, 32'h60); peek(3, 3);
    wr(3, 32'h20); peek(3, 12);
    wr(3, 32'h40); peek(3, 10);

    cur_req = "R12"; // counter write ignored
    wr(1, 32'h0); wr(2, 32'h5A); peek(2, 2);

    cur_req = "R11"; // cause flag retention
    wr(7, 32'h0); peek(7, 2);
    @(negedge clk_i); rst_ni = 0; peek(7, 2); rst_ni = 1; peek(7, 2);
    por_ni = 0; peek(7, 2); por_ni = 1; peek(7, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule